// File: doc/BRIEF.md
# DMA Channel Security Fault Checker

This block sits beside the instruction decoder of a multi-channel DMA engine and screens every decoded instruction issued by a channel thread before it takes effect. Three conditions are treated as faults: a peripheral flush aimed at a peripheral whose security attribute marks it secure, a channel-control write from a non-secure thread that requests a secure bus transaction, and a channel-control write whose source or destination beat size exceeds 64 bits. A faulting instruction is reduced to a no-op. The block then sets the channel's bit in a sticky fault status vector, records the cause in that channel's fault type bits, and drives the channel through a short faulting sequence.

A flush to a non-secure peripheral is allowed. It clears the stored request state of that peripheral and emits a one-cycle pulse that asks the peripheral to report its level status again. A faulted channel stays parked until a kill command returns it to the running state. Software clears the fault status bits with explicit write-one-to-clear strobes.

Top module: `dma_sec_fault_chk`

## Requirements
- R1: A flush (op code 1) whose target peripheral has security bit 0 (secure) drives nop_o high in the same cycle. On the next edge it sets fsr_o for the issuing channel, sets fault type bit 0 (peripheral error) and moves the channel to state 1 (faulting-completing).
- R2: A flush to a peripheral with security bit 1 (non-secure) leaves nop_o low. On the next edge it clears periph_req_o for that peripheral and raises resend_o for that peripheral for exactly one cycle.
- R3: A channel-control write (op code 2) from a non-secure thread (thread_ns=1) with a secure bus attribute (ccr_ns=0) drives nop_o high. It sets fsr_o, sets fault type bit 1 (read/write error) and moves the channel to state 1.
- R4: A channel-control write from a secure thread (thread_ns=0) raises no read/write error, whichever bus attribute it requests.
- R5: On a channel-control write, a source or destination size code above 3 (beat bytes are 2 to the power of the code, so 3 is 64 bits) sets fault type bit 2 (size error), drives nop_o high and faults the channel. Codes of 3 or below raise no size error.
- R6: Fault type bits accumulate. One instruction, or successive faults, may set several bits at once.
- R7: Channel state is encoded as 0 running, 1 faulting-completing and 2 faulting. State 1 moves to state 2 one cycle later, and state 2 holds until a kill.
- R8: A kill for a channel returns it to state 0 and clears its fault type bits on the next edge. Its fsr_o bit is left unchanged.
- R9: An fsr_o bit stays set until the matching fsr_clr_i bit is pulsed. If a new fault and a clear arrive in the same cycle, the new fault wins.
- R10: An instruction from a channel that is not running, or from a channel killed in the same cycle, drives nop_o high and has no effect on any state.
- R11: periph_req_i bits set the matching periph_req_o bits, which hold until an allowed flush clears them. If a flush and a new request hit the same peripheral in the same cycle, the clear wins.
- R12: Other op codes (0 and 3) never fault and leave nop_o low when the channel is running and not being killed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_valid_i | input | 1 | Decoded instruction present |
| issue_ch_i | input | CH_W | Issuing channel |
| issue_op_i | input | 2 | 0 other, 1 flush, 2 channel-control write, 3 other |
| issue_periph_i | input | P_W | Flush target peripheral |
| issue_thread_ns_i | input | 1 | Issuing thread is non-secure |
| issue_ccr_ns_i | input | 1 | Requested bus attribute is non-secure |
| issue_src_size_i | input | SIZE_W | Source beat size code |
| issue_dst_size_i | input | SIZE_W | Destination beat size code |
| periph_ns_i | input | NUM_PERIPH | Per-peripheral security bit, 1 non-secure |
| periph_req_i | input | NUM_PERIPH | Peripheral request set strobes |
| kill_valid_i | input | 1 | Kill command present |
| kill_ch_i | input | CH_W | Channel to kill |
| fsr_clr_i | input | NUM_CH | Write-one-to-clear for fault status |
| nop_o | output | 1 | Current instruction is executed as a no-op |
| fsr_o | output | NUM_CH | Sticky fault status, one bit per channel |
| ftr_o | output | 3*NUM_CH | Fault type bits per channel: bit0 periph, bit1 rd/wr, bit2 size |
| ch_state_o | output | 2*NUM_CH | Channel state per channel |
| periph_req_o | output | NUM_PERIPH | Stored peripheral request state |
| resend_o | output | NUM_PERIPH | One-cycle level status resend request |

## Verification
On every cycle, the assertions check the advance from faulting-completing to faulting, the hold of the faulting state, the effect of a kill, the stickiness of fault status, the absence of read/write errors from secure threads, and the clear-plus-pulse pair after an allowed flush. Only the bench's scenarios can show that the right fault type bit lands on the right channel. The same holds for the same-cycle collisions: kill against issue, set against clear, and request against flush. The bench also shows that instructions from parked channels leave every output untouched.

// File: rtl/dma_sfc_pkg.sv
package dma_sfc_pkg;
  typedef enum logic [1:0] {
    CH_RUN   = 2'd0,
    CH_FCOMP = 2'd1,
    CH_FAULT = 2'd2
  } ch_state_e;

  localparam int FT_W      = 3;
  localparam int FT_PERIPH = 0;
  localparam int FT_RDWR   = 1;
  localparam int FT_SIZE   = 2;

  localparam logic [1:0] OP_FLUSH = 2'd1;
  localparam logic [1:0] OP_CCR   = 2'd2;
endpackage

// File: rtl/dma_sfc_decode.sv
module dma_sfc_decode
  import dma_sfc_pkg::*;
#(
  parameter int SIZE_W   = 3,
  parameter int MAX_SIZE = 3
) (
  input  logic [1:0]        op_i,
  input  logic              thread_ns_i,
  input  logic              ccr_ns_i,
  input  logic [SIZE_W-1:0] src_size_i,
  input  logic [SIZE_W-1:0] dst_size_i,
  input  logic              periph_ns_i,
  output logic [FT_W-1:0]   flt_o,
  output logic              flush_ok_o
);
  localparam logic [SIZE_W-1:0] SIZE_LIM = SIZE_W'(MAX_SIZE);

  always_comb begin
    flt_o      = '0;
    flush_ok_o = 1'b0;
    if (op_i == OP_FLUSH) begin
      flt_o[FT_PERIPH] = !periph_ns_i;
      flush_ok_o       = periph_ns_i;
    end
    if (op_i == OP_CCR) begin
      flt_o[FT_RDWR] = thread_ns_i && !ccr_ns_i;
      flt_o[FT_SIZE] = (src_size_i > SIZE_LIM) || (dst_size_i > SIZE_LIM);
    end
  end
endmodule

// File: rtl/dma_sfc_chan.sv
module dma_sfc_chan
  import dma_sfc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hit_i,
  input  logic [FT_W-1:0] flt_i,
  input  logic            kill_i,
  input  logic            fsr_clr_i,
  output logic            running_o,
  output ch_state_e       state_o,
  output logic [FT_W-1:0] ftr_o,
  output logic            fsr_o
);
  logic take_fault;
  assign running_o  = (state_o == CH_RUN);
  assign take_fault = hit_i && running_o && !kill_i && (|flt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= CH_RUN;
      ftr_o   <= '0;
      fsr_o   <= 1'b0;
    end else begin
      if (kill_i) begin
        state_o <= CH_RUN;
        ftr_o   <= '0;
      end else begin
        unique case (state_o)
          CH_RUN:   if (take_fault) state_o <= CH_FCOMP;
          CH_FCOMP: state_o <= CH_FAULT;
          default:  state_o <= CH_FAULT;
        endcase
        if (take_fault) ftr_o <= ftr_o | flt_i;
      end
      // new fault beats a same-cycle clear
      if (take_fault)     fsr_o <= 1'b1;
      else if (fsr_clr_i) fsr_o <= 1'b0;
    end
  end

  p_fcomp_advance_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CH_FCOMP && !kill_i) |=> (state_o == CH_FAULT));
  p_fault_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CH_FAULT && !kill_i) |=> (state_o == CH_FAULT));
  p_kill_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> (state_o == CH_RUN && ftr_o == '0));
  p_fsr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsr_o && !fsr_clr_i) |=> fsr_o);
endmodule

// File: rtl/dma_sfc_flush.sv
module dma_sfc_flush #(
  parameter int NUM_PERIPH = 8,
  parameter int P_W        = $clog2(NUM_PERIPH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PERIPH-1:0] req_set_i,
  input  logic                  flush_ok_i,
  input  logic [P_W-1:0]        periph_i,
  output logic [NUM_PERIPH-1:0] req_o,
  output logic [NUM_PERIPH-1:0] resend_o
);
  logic [NUM_PERIPH-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (flush_ok_i) clr_mask[periph_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o    <= '0;
      resend_o <= '0;
    end else begin
      req_o    <= (req_o | req_set_i) & ~clr_mask;
      resend_o <= clr_mask;
    end
  end

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_chk
    p_flush_resend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_ok_i && periph_i == P_W'(p)) |=> (resend_o[p] && !req_o[p]));
  end
  p_resend_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(resend_o));
endmodule

// File: rtl/dma_sec_fault_chk.sv
module dma_sec_fault_chk
  import dma_sfc_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int NUM_PERIPH = 8,
  parameter int SIZE_W     = 3,
  parameter int MAX_SIZE   = 3,
  parameter int CH_W       = $clog2(NUM_CH),
  parameter int P_W        = $clog2(NUM_PERIPH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   issue_valid_i,
  input  logic [CH_W-1:0]        issue_ch_i,
  input  logic [1:0]             issue_op_i,
  input  logic [P_W-1:0]         issue_periph_i,
  input  logic                   issue_thread_ns_i,
  input  logic                   issue_ccr_ns_i,
  input  logic [SIZE_W-1:0]      issue_src_size_i,
  input  logic [SIZE_W-1:0]      issue_dst_size_i,
  input  logic [NUM_PERIPH-1:0]  periph_ns_i,
  input  logic [NUM_PERIPH-1:0]  periph_req_i,
  input  logic                   kill_valid_i,
  input  logic [CH_W-1:0]        kill_ch_i,
  input  logic [NUM_CH-1:0]      fsr_clr_i,
  output logic                   nop_o,
  output logic [NUM_CH-1:0]      fsr_o,
  output logic [FT_W*NUM_CH-1:0] ftr_o,
  output logic [2*NUM_CH-1:0]    ch_state_o,
  output logic [NUM_PERIPH-1:0]  periph_req_o,
  output logic [NUM_PERIPH-1:0]  resend_o
);
  logic [FT_W-1:0]   flt;
  logic              flush_allowed;
  logic [NUM_CH-1:0] running;
  logic              killed_now;
  logic              live;

  dma_sfc_decode #(.SIZE_W(SIZE_W), .MAX_SIZE(MAX_SIZE)) u_decode (
    .op_i        (issue_op_i),
    .thread_ns_i (issue_thread_ns_i),
    .ccr_ns_i    (issue_ccr_ns_i),
    .src_size_i  (issue_src_size_i),
    .dst_size_i  (issue_dst_size_i),
    .periph_ns_i (periph_ns_i[issue_periph_i]),
    .flt_o       (flt),
    .flush_ok_o  (flush_allowed)
  );

  assign killed_now = kill_valid_i && (kill_ch_i == issue_ch_i);
  assign live       = issue_valid_i && running[issue_ch_i] && !killed_now;
  assign nop_o      = issue_valid_i && (!live || (|flt));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ch_state_e st;
    dma_sfc_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (issue_valid_i && issue_ch_i == CH_W'(c)),
      .flt_i     (flt),
      .kill_i    (kill_valid_i && kill_ch_i == CH_W'(c)),
      .fsr_clr_i (fsr_clr_i[c]),
      .running_o (running[c]),
      .state_o   (st),
      .ftr_o     (ftr_o[c*FT_W +: FT_W]),
      .fsr_o     (fsr_o[c])
    );
    assign ch_state_o[c*2 +: 2] = st;
  end

  dma_sfc_flush #(.NUM_PERIPH(NUM_PERIPH), .P_W(P_W)) u_flush (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_set_i  (periph_req_i),
    .flush_ok_i (live && flush_allowed),
    .periph_i   (issue_periph_i),
    .req_o      (periph_req_o),
    .resend_o   (resend_o)
  );

  p_secure_thread_no_rdwr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !issue_thread_ns_i) |-> !flt[FT_RDWR]);
  p_fault_is_nop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && (|flt)) |-> nop_o);
  p_fault_reaches_fsr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && (|flt)) |=> fsr_o[$past(issue_ch_i)]);
endmodule

// File: tb/dma_sec_fault_chk_test.sv
module dma_sec_fault_chk_test;
  localparam int CLK_P = 10;
  localparam int NC = 4, NP = 8;

  logic clk = 0, rst_n = 0;
  logic iv = 0; logic [1:0] ich = 0; logic [1:0] iop = 0; logic [2:0] ip = 0;
  logic tns = 0, cns = 0; logic [2:0] ss = 0, ds = 0;
  logic [NP-1:0] pns = 8'hF0, preq = 0;
  logic kv = 0; logic [1:0] kch = 0; logic [NC-1:0] fclr = 0;
  logic nop; logic [NC-1:0] fsr; logic [3*NC-1:0] ftr; logic [2*NC-1:0] cst;
  logic [NP-1:0] req, rsd;

  int checks = 0, fails = 0;
  int m_st [NC]; logic [2:0] m_ftr [NC]; logic [NC-1:0] m_fsr = 0;
  logic [NP-1:0] m_req = 0, m_rsd = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_sec_fault_chk uut (
    .clk_i(clk), .rst_ni(rst_n), .issue_valid_i(iv), .issue_ch_i(ich), .issue_op_i(iop),
    .issue_periph_i(ip), .issue_thread_ns_i(tns), .issue_ccr_ns_i(cns),
    .issue_src_size_i(ss), .issue_dst_size_i(ds), .periph_ns_i(pns), .periph_req_i(preq),
    .kill_valid_i(kv), .kill_ch_i(kch), .fsr_clr_i(fclr), .nop_o(nop), .fsr_o(fsr),
    .ftr_o(ftr), .ch_state_o(cst), .periph_req_o(req), .resend_o(rsd));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_flt();
    logic [2:0] f = 0;
    if (iop == 2'd1) f[0] = !pns[ip];
    if (iop == 2'd2) begin
      f[1] = tns && !cns;
      f[2] = (ss > 3) || (ds > 3);
    end
    return f;
  endfunction

  // inputs already driven after a negedge; check comb output, advance model, check registers
  task automatic step(string tag);
    logic [2:0] f; logic live; logic [NP-1:0] clr;
    #1;
    f = exp_flt();
    live = iv && m_st[ich] == 0 && !(kv && kch == ich);
    chk(tag, "nop_o", nop, iv && (!live || f != 0));
    clr = 0;
    if (live && iop == 2'd1 && pns[ip]) clr[ip] = 1;
    for (int c = 0; c < NC; c++) begin
      logic tf;
      tf = live && ich == c && f != 0;
      if (kv && kch == c) begin m_st[c] = 0; m_ftr[c] = 0; end
      else begin
        if (m_st[c] != 0) m_st[c] = 2;
        else if (tf) m_st[c] = 1;
        if (tf) m_ftr[c] |= f;
      end
      if (tf) m_fsr[c] = 1; else if (fclr[c]) m_fsr[c] = 0;
    end
    m_req = (m_req | preq) & ~clr;
    m_rsd = clr;
    @(posedge clk); @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk(tag, $sformatf("state ch%0d", c), cst[c*2 +: 2], m_st[c]);
      chk(tag, $sformatf("ftr ch%0d", c), ftr[c*3 +: 3], m_ftr[c]);
    end
    chk(tag, "fsr_o", fsr, m_fsr);
    chk(tag, "periph_req_o", req, m_req);
    chk(tag, "resend_o", rsd, m_rsd);
  endtask

  task automatic idle();
    iv = 0; iop = 0; kv = 0; fclr = 0; preq = 0;
  endtask

  task automatic issue(int ch, int op, int p, bit t, bit c, int s, int d);
    iv = 1; ich = ch; iop = op; ip = p; tns = t; cns = c; ss = s; ds = d;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin m_st[c] = 0; m_ftr[c] = 0; end
    void'($urandom(32'h5EC0_D4A1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R9", "reset fsr", fsr, 0);
    chk("R7", "reset state", cst, 0);
    chk("R11", "reset req", req, 0);
    // R11 request set
    idle(); preq = 8'hFF; step("R11");
    // R2 allowed flush, then pulse drops
    idle(); issue(0, 1, 5, 1, 1, 0, 0); step("R2");
    idle(); step("R2");
    // R1 secure flush, then R7 advance
    idle(); issue(1, 1, 2, 1, 1, 0, 0); step("R1");
    idle(); step("R7");
    // R10 parked channel issues an allowed flush: no effect
    idle(); issue(1, 1, 6, 1, 1, 0, 0); step("R10");
    // R6 rw + size in one instruction
    idle(); issue(2, 2, 0, 1, 0, 4, 0); step("R6");
    // R4 secure thread, secure attr, max legal size
    idle(); issue(3, 2, 0, 0, 0, 3, 3); step("R4");
    idle(); issue(3, 2, 0, 0, 1, 0, 0); step("R4");
    // R5 destination too wide
    idle(); issue(3, 2, 0, 1, 1, 0, 5); step("R5");
    // R12 other op
    idle(); issue(0, 0, 0, 1, 0, 7, 7); step("R12");
    idle(); issue(0, 3, 1, 1, 0, 7, 7); step("R12");
    // R8 kill keeps fsr
    idle(); kv = 1; kch = 1; step("R8");
    // R9 clear, and set wins over clear
    idle(); fclr = 4'b0010; step("R9");
    idle(); issue(0, 1, 3, 1, 1, 0, 0); fclr = 4'b0001; step("R9");
    // R10 kill same cycle as issue
    idle(); issue(2, 1, 4, 1, 1, 0, 0); kv = 1; kch = 2; step("R10");
    // R11 clear beats set on same peripheral
    idle(); preq = 8'hFF; step("R11");
    idle(); issue(2, 1, 7, 1, 1, 0, 0); preq = 8'h80; step("R11");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom_range(0, 3) != 0)
        issue($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 7),
              $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 4), $urandom_range(0, 4));
      if ($urandom_range(0, 4) == 0) begin kv = 1; kch = $urandom_range(0, 3); end
      if ($urandom_range(0, 5) == 0) fclr = $urandom_range(0, 15);
      if ($urandom_range(0, 3) == 0) preq = $urandom_range(0, 255);
      if ($urandom_range(0, 31) == 0) pns = $urandom_range(0, 255);
      step("R6");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule